// File: doc/BRIEF.md
# Code Byte Prefetch Queue

This block fetches instruction bytes ahead of the consumer that executes them. It keeps a 16-bit code segment and a 16-bit fetch offset. From these two values it forms a 20-bit physical byte address, and it issues one-byte reads on a request/ready memory interface. Read data comes back in order on a separate valid strobe. The returned bytes go into a six-entry queue, and the consumer drains that queue one byte at a time through a valid/ready handshake. Fetching goes on by itself whenever there is room, so memory reads overlap with consumption.

A redirect input loads a new segment and offset in a single cycle. The same cycle empties the queue. Any reads still in flight at that point are marked stale, and their responses are thrown away when they arrive. Bytes of the old stream therefore never reach the consumer.

Top module: `code_prefetch_unit`

## Requirements
- R1: After synchronous active-high reset, `ins_valid` is 0, the segment is FFFFH and the offset is 0000H, so the first request goes out on `mem_req` with `mem_addr` = FFFF0H.
- R2: While `mem_req` is 1, `mem_addr` equals (segment × 16 + offset) modulo 2^20. For example, segment 4321H with offset 1000H gives 44210H, and segment FFFFH with offset FFFFH gives 0FFEFH.
- R3: Each request accepted (`mem_req` and `mem_ready` both 1) advances the offset by one. The offset wraps from FFFFH to 0000H and leaves the segment unchanged.
- R4: Bytes leave on `ins_byte` oldest first, one for each cycle in which `ins_valid` and `ins_ready` are both 1. While the byte waits for the consumer and no redirect occurs, `ins_valid` and `ins_byte` stay the same.
- R5: Queued bytes plus live reads in flight never exceed the queue depth of 6. `mem_req` is 1 exactly when that sum is below 6 and the in-flight limit of R8 allows it, so fetching continues while the consumer is draining.
- R6: A cycle with `br_valid` = 1 loads `br_seg` and `br_ofs`. In the next cycle `ins_valid` is 0 and the next request uses the new address.
- R7: Responses to reads accepted before or in a redirect cycle are dropped and never appear on `ins_byte`.
- R8: Reads in flight, live and stale together, never exceed MAX_INFLIGHT (default 4). `mem_req` stays 0 while that limit is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Redirect: load new segment and offset, flush |
| br_seg | input | 16 | New code segment value |
| br_ofs | input | 16 | New fetch offset value |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Physical byte address of the request |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data returned (in request order) |
| mem_rdata | input | 8 | Returned byte |
| ins_valid | output | 1 | A queued byte is available |
| ins_byte | output | 8 | Oldest queued byte |
| ins_ready | input | 1 | Consumer takes the byte this cycle |

## Verification
Some behaviours hold on every cycle and are checked by the assertions. The queue fill plus live reads stays within the depth, and in-flight reads stay within their limit. The offset steps by one on each accepted request. A redirect loads the offset and clears the output valid and the live count. A waiting byte stays stable. Other behaviours can only be shown by the bench's scenarios, because they depend on the bench's memory model returning address-derived data. These are the exact byte order, the address arithmetic with its wrap corners, and the silent drop of stale responses when a redirect is followed by late data.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int unsigned SEG_W  = 16;
    localparam int unsigned OFS_W  = 16;
    localparam int unsigned SHIFT  = 4;
    localparam int unsigned PA_W   = 20;
    localparam int unsigned BYTE_W = 8;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [PA_W-1:0]   paddr_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pfq_addr_gen.sv
module pfq_addr_gen
    import pfq_pkg::*;
(
    input  seg_t   seg_i,
    input  ofs_t   ofs_i,
    output paddr_t pa_o
);
    // Segment shifted by SHIFT bits plus the zero-extended offset; carry out of
    // the top bit is dropped by the PA_W-wide sum.
    localparam int unsigned SEG_SH_W = SEG_W + SHIFT;

    logic [SEG_SH_W-1:0] seg_sh;
    paddr_t              base;
    paddr_t              off;

    always_comb begin
        seg_sh = {seg_i, {SHIFT{1'b0}}};
        base   = PA_W'(seg_sh);
        off    = PA_W'(ofs_i);
        pa_o   = base + off;
    end
endmodule

// File: rtl/pfq_queue.sv
module pfq_queue
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  byte_t                      push_data,
    input  logic                       pop,
    output logic                       valid,
    output byte_t                      data,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] slots;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
    } q_state_t;

    q_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    logic do_pop;
    logic do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((int'(st_q.cnt) < DEPTH) || do_pop);
        if (do_pop) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        if (do_push) begin
            st_d.slots[st_q.wr] = push_data;
            st_d.wr             = ptr_inc(st_q.wr);
        end
        st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = (st_q.cnt != '0);
    assign data  = st_q.slots[st_q.rd];
    assign fill  = st_q.cnt;
endmodule

// File: rtl/pfq_seq.sv
module pfq_seq
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH        = 6,
    parameter int unsigned MAX_INFLIGHT = 4,
    parameter seg_t        RESET_SEG    = 16'hFFFF,
    parameter ofs_t        RESET_OFS    = 16'h0000
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              redirect,
    input  seg_t                              redir_seg,
    input  ofs_t                              redir_ofs,
    input  logic                              mem_ready,
    input  logic                              mem_rvalid,
    input  logic [$clog2(DEPTH+1)-1:0]        fill,
    output seg_t                              seg,
    output ofs_t                              ofs,
    output logic                              req,
    output logic                              enq,
    output logic [$clog2(MAX_INFLIGHT+1)-1:0] live,
    output logic [$clog2(MAX_INFLIGHT+1)-1:0] stale
);
    localparam int unsigned OUT_W = $clog2(MAX_INFLIGHT + 1);

    typedef struct packed {
        seg_t             seg;
        ofs_t             ofs;
        logic [OUT_W-1:0] live;
        logic [OUT_W-1:0] stale;
    } s_state_t;

    s_state_t st_d, st_q;

    logic accept;
    logic rsp_stale;
    logic rsp_live;

    always_comb begin
        // Reserve a queue slot for every live read; cap all outstanding reads.
        req = ((int'(fill) + int'(st_q.live)) < DEPTH) &&
              ((int'(st_q.live) + int'(st_q.stale)) < MAX_INFLIGHT);
        accept    = req && mem_ready;
        rsp_stale = mem_rvalid && (st_q.stale != '0);
        rsp_live  = mem_rvalid && (st_q.stale == '0) && (st_q.live != '0);
        enq       = rsp_live && !redirect;

        st_d = st_q;
        if (redirect) begin
            st_d.seg   = redir_seg;
            st_d.ofs   = redir_ofs;
            st_d.live  = '0;
            st_d.stale = st_q.stale - OUT_W'(rsp_stale)
                       + st_q.live  - OUT_W'(rsp_live)
                       + OUT_W'(accept);
        end else begin
            if (accept) begin
                st_d.ofs = st_q.ofs + 1'b1;
            end
            st_d.live  = st_q.live + OUT_W'(accept) - OUT_W'(rsp_live);
            st_d.stale = st_q.stale - OUT_W'(rsp_stale);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.seg   <= RESET_SEG;
            st_q.ofs   <= RESET_OFS;
            st_q.live  <= '0;
            st_q.stale <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg   = st_q.seg;
    assign ofs   = st_q.ofs;
    assign live  = st_q.live;
    assign stale = st_q.stale;
endmodule

// File: rtl/code_prefetch_unit.sv
module code_prefetch_unit
    import pfq_pkg::*;
#(
    parameter int unsigned DEPTH        = 6,
    parameter int unsigned MAX_INFLIGHT = 4,
    parameter logic [15:0] RESET_SEG    = 16'hFFFF,
    parameter logic [15:0] RESET_OFS    = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        br_valid,
    input  logic [15:0] br_seg,
    input  logic [15:0] br_ofs,
    output logic        mem_req,
    output logic [19:0] mem_addr,
    input  logic        mem_ready,
    input  logic        mem_rvalid,
    input  logic [7:0]  mem_rdata,
    output logic        ins_valid,
    output logic [7:0]  ins_byte,
    input  logic        ins_ready
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam int unsigned OUT_W = $clog2(MAX_INFLIGHT + 1);

    seg_t             cur_seg;
    ofs_t             cur_ofs;
    logic             enq;
    logic [CNT_W-1:0] q_fill;
    logic [OUT_W-1:0] n_live;
    logic [OUT_W-1:0] n_stale;

    pfq_seq #(
        .DEPTH       (DEPTH),
        .MAX_INFLIGHT(MAX_INFLIGHT),
        .RESET_SEG   (RESET_SEG),
        .RESET_OFS   (RESET_OFS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .redirect  (br_valid),
        .redir_seg (br_seg),
        .redir_ofs (br_ofs),
        .mem_ready (mem_ready),
        .mem_rvalid(mem_rvalid),
        .fill      (q_fill),
        .seg       (cur_seg),
        .ofs       (cur_ofs),
        .req       (mem_req),
        .enq       (enq),
        .live      (n_live),
        .stale     (n_stale)
    );

    pfq_addr_gen u_agen (
        .seg_i(cur_seg),
        .ofs_i(cur_ofs),
        .pa_o (mem_addr)
    );

    pfq_queue #(
        .DEPTH(DEPTH)
    ) u_queue (
        .clk      (clk),
        .rst      (rst),
        .flush    (br_valid),
        .push     (enq),
        .push_data(mem_rdata),
        .pop      (ins_ready),
        .valid    (ins_valid),
        .data     (ins_byte),
        .fill     (q_fill)
    );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int unsigned DEPTH        = 6,
    parameter int unsigned MAX_INFLIGHT = 4
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              br_valid,
    input logic [15:0]                       br_ofs,
    input logic                              mem_req,
    input logic                              mem_ready,
    input logic                              ins_valid,
    input logic                              ins_ready,
    input logic [7:0]                        ins_byte,
    input logic [15:0]                       cur_ofs,
    input logic [$clog2(DEPTH+1)-1:0]        q_fill,
    input logic [$clog2(MAX_INFLIGHT+1)-1:0] n_live,
    input logic [$clog2(MAX_INFLIGHT+1)-1:0] n_stale
);
    assert_slot_budget_R5: assert property (@(posedge clk) disable iff (rst)
        (int'(q_fill) + int'(n_live)) <= DEPTH);

    assert_inflight_cap_R8: assert property (@(posedge clk) disable iff (rst)
        (int'(n_live) + int'(n_stale)) <= MAX_INFLIGHT);

    assert_ofs_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && !br_valid) |=> (cur_ofs == $past(cur_ofs) + 16'd1));

    assert_redirect_load_R6: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> ((cur_ofs == $past(br_ofs)) && !ins_valid));

    assert_redirect_kills_R7: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> (n_live == '0));

    assert_hold_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_ready && !br_valid) |=> (ins_valid && $stable(ins_byte)));
endmodule

bind code_prefetch_unit pfq_checker #(
    .DEPTH       (DEPTH),
    .MAX_INFLIGHT(MAX_INFLIGHT)
) u_pfq_checker (
    .clk      (clk),
    .rst      (rst),
    .br_valid (br_valid),
    .br_ofs   (br_ofs),
    .mem_req  (mem_req),
    .mem_ready(mem_ready),
    .ins_valid(ins_valid),
    .ins_ready(ins_ready),
    .ins_byte (ins_byte),
    .cur_ofs  (cur_ofs),
    .q_fill   (q_fill),
    .n_live   (n_live),
    .n_stale  (n_stale)
);

// File: tb/code_prefetch_unit_test.sv
`timescale 1ns/1ps
module code_prefetch_unit_test;
    localparam int DEPTH = 6;
    localparam int MAXI  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_valid = 1'b0;
    logic [15:0] br_seg = '0;
    logic [15:0] br_ofs = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        ins_valid;
    logic [7:0]  ins_byte;
    logic        ins_ready = 1'b0;

    always #5 clk = ~clk;

    code_prefetch_unit uut (
        .clk(clk), .rst(rst),
        .br_valid(br_valid), .br_seg(br_seg), .br_ofs(br_ofs),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ins_valid(ins_valid), .ins_byte(ins_byte), .ins_ready(ins_ready)
    );

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    logic [19:0] mq[$];
    logic [7:0]  exp_q[$];
    logic [15:0] m_seg = 16'hFFFF;
    logic [15:0] m_ofs = 16'h0000;
    bit          prev_br = 1'b0;
    bit          prev_hold = 1'b0;
    logic [7:0]  prev_byte = '0;

    function automatic logic [7:0] mem_dat(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[3:0]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] sum;
        sum = {1'b0, s, 4'h0} + {5'h0, o};
        return sum[19:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: inputs at the falling edge, checks and model update, then the
    // rising edge, ending at the next falling edge.
    task automatic cyc(input bit mr, input bit orr, input bit br,
                       input logic [15:0] s, input logic [15:0] o, input bit rsp_en);
        bit resp;
        bit acc;
        bit exp_req;
        logic [7:0] eb;
        mem_ready = mr;
        ins_ready = orr;
        br_valid  = br;
        br_seg    = s;
        br_ofs    = o;
        resp      = rsp_en && (mq.size() > 0);
        mem_rvalid = resp;
        mem_rdata  = resp ? mem_dat(mq[0]) : 8'h00;
        #1;
        if (prev_br) check(!ins_valid, "R6 valid after redirect", 32'(ins_valid), 32'd0);
        if (prev_hold) begin
            check(ins_valid && ins_byte == prev_byte, "R4 hold while stalled",
                  32'(ins_byte), 32'(prev_byte));
        end
        exp_req = (exp_q.size() < DEPTH) && (mq.size() < MAXI);
        check(mem_req == exp_req, "R5/R8 request gating", 32'(mem_req), 32'(exp_req));
        if (mem_req) begin
            check(mem_addr == phys(m_seg, m_ofs), "R2 address",
                  32'(mem_addr), 32'(phys(m_seg, m_ofs)));
        end
        if (ins_valid && orr) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected byte", 32'(ins_byte), 32'hFFFFFFFF);
            end else begin
                eb = exp_q.pop_front();
                check(ins_byte == eb, "R4 byte order", 32'(ins_byte), 32'(eb));
            end
        end
        prev_br   = br;
        prev_hold = ins_valid && !orr && !br;
        prev_byte = ins_byte;
        acc = mem_req && mr;
        if (resp) void'(mq.pop_front());
        if (acc) begin
            mq.push_back(mem_addr);
            if (!br) exp_q.push_back(mem_dat(mem_addr));
            m_ofs = m_ofs + 16'd1;
        end
        if (br) begin
            exp_q.delete();
            m_seg = s;
            m_ofs = o;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(!ins_valid, "R1 ins_valid after reset", 32'(ins_valid), 32'd0);
        check(mem_req, "R1 mem_req after reset", 32'(mem_req), 32'd1);
        check(mem_addr == 20'hFFFF0, "R1 reset address", 32'(mem_addr), 32'hFFFF0);

        // R2 worked example
        cyc(1'b0, 1'b0, 1'b1, 16'h4321, 16'h1000, 1'b0);
        check(mem_addr == 20'h44210, "R2 4321:1000", 32'(mem_addr), 32'h44210);

        // R2/R3 wrap corners
        cyc(1'b0, 1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0);
        check(mem_addr == 20'h0FFEF, "R2 FFFF:FFFF", 32'(mem_addr), 32'h0FFEF);
        cyc(1'b1, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0);
        check(mem_addr == 20'hFFFF0, "R3 offset wrap", 32'(mem_addr), 32'hFFFF0);

        // R8: responses held, in-flight cap reached
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0);
        check(!mem_req, "R8 cap holds request", 32'(mem_req), 32'd0);

        // R7: redirect with four reads in flight, then drain them
        cyc(1'b0, 1'b1, 1'b1, 16'h1234, 16'h00F0, 1'b0);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 1'b1);
        check(!ins_valid, "R7 stale data dropped", 32'(ins_valid), 32'd0);
        check(mem_addr == 20'h12430, "R6 new address", 32'(mem_addr), 32'h12430);

        // R5: consumer stalled, memory fast, queue fills to depth
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1);
        check(!mem_req && exp_q.size() == DEPTH, "R5 full queue stops fetch",
              32'(mem_req), 32'd0);
        // Drain while fetch overlaps
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b0, 16'h0, 16'h0, 1'b1);

        // Random mix
        for (int i = 0; i < 6000; i++) begin
            cyc(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 40) == 0,
                16'($urandom), 16'($urandom), ($urandom % 2) == 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule